// File: doc/BRIEF.md
# Cache Tag Invalidation Sequencer

This block controls the tag store of a second-level cache on a 486-style front-side bus. It owns a synchronous single-port tag RAM with one 8-bit entry per cache line. It serves three kinds of processor request, each started by a one-cycle address strobe: a hit/miss lookup, a line-fill tag write, and the invalidate special cycle that the processor issues for its cache-invalidate instructions. Every request is answered by a one-cycle `rdy` pulse.

Because each entry stores a real valid bit, the cache can be emptied. An invalidate request starts a hardware sweep. The sweep takes two clocks per line: one to present the line address and one to write zero. `rdy` is withheld until the last line has been cleared. A configuration input selects a second behaviour, in which the invalidate is acknowledged at once and the tags are left alone, as an always-valid cache would do. Reset does not touch the tag RAM, so software must issue an invalidate before it turns the cache on. One request can wait in a holding slot while another operation runs, and requests that arrive during a sweep are served after it.

Top module: `tag_sweep_ctrl`

## Requirements
- R1: Each tag entry is 8 bits wide. Bit 7 is the valid flag and bits 6:0 are the address tag. A request address splits into a line index in bits LINE_W-1:0 and a tag in bits LINE_W+6:LINE_W, where LINE_W = log2(NUM_LINES).
- R2: `reqKind` 2'b00 is a lookup. `rdy` pulses at the third clock edge after the edge that samples `ads`, and `hit` is 1 with it only if the stored valid bit is set and the stored tag equals the request tag.
- R3: `reqKind` 2'b01 is a line fill. It writes {1, request tag} to the indexed entry, and `rdy` pulses at the second edge after the edge that samples `ads`.
- R4: With `instantAck` low, `reqKind` 2'b10 or 2'b11 (invalidate) writes zero to every entry exactly once, in ascending index order. Each line takes two cycles: an address cycle with `tagWe` low, then a write cycle with the same `tagAddr`.
- R5: The invalidate `rdy` pulses only once the last line is cleared, at edge 2*NUM_LINES+1 after the edge that samples `ads`.
- R6: With `instantAck` high, an invalidate pulses `rdy` at the first edge after the sampling edge and performs no tag write, so entries that hit before it still hit afterwards.
- R7: A request strobed while an operation, including a sweep, is in progress is held and served once that operation completes, with no `rdy` of its own before then.
- R8: While reset is asserted, `rdy`, `hit` and `tagWe` are low. Reset leaves tag RAM contents untouched, so entries valid before reset still hit.
- R9: `rdy` is a single-cycle pulse, one per request, and `hit` is never high without `rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instantAck | input | 1 | 1: acknowledge invalidate at once without clearing tags |
| ads | input | 1 | One-cycle request strobe |
| reqKind | input | 2 | 00 lookup, 01 fill, 1x invalidate |
| reqAddr | input | LINE_W+7 | Request address: tag above line index |
| rdy | output | 1 | Request completion pulse |
| hit | output | 1 | Lookup result, valid with `rdy` |
| tagAddr | output | LINE_W | Tag RAM line address |
| tagWrData | output | 8 | Tag RAM write data |
| tagWe | output | 1 | Tag RAM write enable |
| tagRdData | input | 8 | Tag RAM read data, one cycle after address |

## Verification
A line counter that skips or repeats an index shows on the tag RAM port during the sweep, because the bench tracks the clear order on every write. A line that is left uncleared shows later as a stray lookup hit. An acknowledge one edge early or late, or a held request released too soon, shows as a `rdy` mismatch against the cycle model in the very cycle it happens. A wrong compare or field position shows in the `hit` of the next lookup to that entry, three edges after its strobe.

// File: rtl/tag_sweep_pkg.sv
package tag_sweep_pkg;

  localparam int TAG_BITS = 7;
  localparam int ENTRY_W  = TAG_BITS + 1;  // valid flag sits on top (R1)

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic takeSlot;   // move held request into the working registers
    logic lineClr;    // restart the sweep line counter
    logic lineInc;    // advance to the next line
    logic selSweep;   // tag RAM address from the line counter
    logic weFill;     // write {valid, tag}
    logic weClear;    // write all-zero entry
    logic ackLook;    // complete a lookup, qualify hit
    logic ackPlain;   // complete without a hit result
  } ctrlStb_t;

endpackage

// File: rtl/tag_sweep_dp.sv
module tag_sweep_dp
  import tag_sweep_pkg::*;
#(
  parameter int NUM_LINES = 32768,
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int REQ_W  = LINE_W + TAG_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ads,
  input  logic [1:0]         reqKind,
  input  logic [REQ_W-1:0]   reqAddr,
  input  ctrlStb_t           stb,
  output logic               slotValid,
  output logic [1:0]         slotKind,
  output logic               lastLine,
  output logic [LINE_W-1:0]  tagAddr,
  output logic [ENTRY_W-1:0] tagWrData,
  output logic               tagWe,
  input  logic [ENTRY_W-1:0] tagRdData,
  output logic               rdy,
  output logic               hit
);

  localparam logic [LINE_W-1:0] LAST_IDX = LINE_W'(NUM_LINES - 1);

  logic [REQ_W-1:0]    slotAddr;
  logic [LINE_W-1:0]   workIdx;
  logic [TAG_BITS-1:0] workTag;
  logic [LINE_W-1:0]   lineCnt;
  logic                hitNow;

  // Holding slot: a strobe is taken only when the slot is empty (R7)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= 1'b0;
      slotKind  <= '0;
      slotAddr  <= '0;
    end else if (stb.takeSlot) begin
      slotValid <= 1'b0;
    end else if (ads && !slotValid) begin
      slotValid <= 1'b1;
      slotKind  <= reqKind;
      slotAddr  <= reqAddr;
    end
  end

  // Working copy of the request being served; index low, tag high (R1)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workIdx <= '0;
      workTag <= '0;
    end else if (stb.takeSlot) begin
      workIdx <= slotAddr[LINE_W-1:0];
      workTag <= slotAddr[REQ_W-1:LINE_W];
    end
  end

  // Sweep line counter; the sequencer stops at the last index (R4, R5)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lineCnt <= '0;
    else if (stb.lineClr) lineCnt <= '0;
    else if (stb.lineInc) lineCnt <= lineCnt + 1'b1;
  end

  assign lastLine = (lineCnt == LAST_IDX);

  // Tag RAM port
  assign tagAddr   = stb.selSweep ? lineCnt : workIdx;
  assign tagWe     = stb.weFill | stb.weClear;
  assign tagWrData = stb.weFill ? {1'b1, workTag} : '0;

  // Hit needs the stored valid flag and a matching tag (R2)
  assign hitNow = tagRdData[ENTRY_W-1] && (tagRdData[TAG_BITS-1:0] == workTag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdy <= 1'b0;
      hit <= 1'b0;
    end else begin
      rdy <= stb.ackLook | stb.ackPlain;
      hit <= stb.ackLook & hitNow;
    end
  end

endmodule

// File: rtl/tag_sweep_fsm.sv
module tag_sweep_fsm
  import tag_sweep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instantAck,
  input  logic       slotValid,
  input  logic [1:0] slotKind,
  input  logic       lastLine,
  output ctrlStb_t   stb
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK_RD,
    ST_LOOK_CMP,
    ST_FILL_WR,
    ST_SWP_ADDR,
    ST_SWP_WR
  } seqState_e;

  seqState_e st, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stb    = '0;
    stNext = st;
    unique case (st)
      ST_IDLE: begin
        if (slotValid) begin
          stb.takeSlot = 1'b1;
          if (slotKind[1]) begin
            if (instantAck) begin
              stb.ackPlain = 1'b1;          // R6: no sweep
            end else begin
              stb.lineClr = 1'b1;
              stNext      = ST_SWP_ADDR;
            end
          end else if (slotKind[0]) begin
            stNext = ST_FILL_WR;
          end else begin
            stNext = ST_LOOK_RD;
          end
        end
      end
      ST_LOOK_RD:  stNext = ST_LOOK_CMP;   // RAM registers the index
      ST_LOOK_CMP: begin
        stb.ackLook = 1'b1;
        stNext      = ST_IDLE;
      end
      ST_FILL_WR: begin
        stb.weFill   = 1'b1;
        stb.ackPlain = 1'b1;
        stNext       = ST_IDLE;
      end
      ST_SWP_ADDR: begin
        stb.selSweep = 1'b1;
        stNext       = ST_SWP_WR;
      end
      ST_SWP_WR: begin
        stb.selSweep = 1'b1;
        stb.weClear  = 1'b1;
        if (lastLine) begin
          stb.ackPlain = 1'b1;              // R5
          stNext       = ST_IDLE;
        end else begin
          stb.lineInc = 1'b1;
          stNext      = ST_SWP_ADDR;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/tag_sweep_ctrl.sv
module tag_sweep_ctrl
  import tag_sweep_pkg::*;
#(
  parameter int NUM_LINES = 32768,
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int REQ_W  = LINE_W + TAG_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instantAck,
  input  logic               ads,
  input  logic [1:0]         reqKind,
  input  logic [REQ_W-1:0]   reqAddr,
  output logic               rdy,
  output logic               hit,
  output logic [LINE_W-1:0]  tagAddr,
  output logic [ENTRY_W-1:0] tagWrData,
  output logic               tagWe,
  input  logic [ENTRY_W-1:0] tagRdData
);

  ctrlStb_t   stb;
  logic       slotValid;
  logic [1:0] slotKind;
  logic       lastLine;

  tag_sweep_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .instantAck (instantAck),
    .slotValid  (slotValid),
    .slotKind   (slotKind),
    .lastLine   (lastLine),
    .stb        (stb)
  );

  tag_sweep_dp #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ads       (ads),
    .reqKind   (reqKind),
    .reqAddr   (reqAddr),
    .stb       (stb),
    .slotValid (slotValid),
    .slotKind  (slotKind),
    .lastLine  (lastLine),
    .tagAddr   (tagAddr),
    .tagWrData (tagWrData),
    .tagWe     (tagWe),
    .tagRdData (tagRdData),
    .rdy       (rdy),
    .hit       (hit)
  );

endmodule

// File: rtl/tag_sweep_chk.sv
module tag_sweep_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rstN,
  input logic          rdy,
  input logic          hit,
  input logic          tagWe,
  input logic [7:0]    tagWrData,
  input logic [AW-1:0] tagAddr
);

  // R9
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdy |=> !rdy);

  // R9
  hit_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> rdy);

  // R4
  we_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    tagWe |=> !tagWe);

  // R4
  clr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tagWe && tagWrData == 8'h00) |-> $stable(tagAddr));

  // R1
  fill_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tagWe && tagWrData != 8'h00) |-> tagWrData[7]);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!rdy && !hit && !tagWe));

endmodule

bind tag_sweep_ctrl tag_sweep_chk #(.AW(LINE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdy       (rdy),
  .hit       (hit),
  .tagWe     (tagWe),
  .tagWrData (tagWrData),
  .tagAddr   (tagAddr)
);

// File: tb/tag_sweep_ctrl_tb.sv
module tag_sweep_ctrl_tb;

  localparam int N     = 64;
  localparam int LW    = $clog2(N);
  localparam int RW    = LW + 7;
  localparam int WD    = 20000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          instantAck = 1'b0;
  logic          ads = 1'b0;
  logic [1:0]    reqKind = 2'b00;
  logic [RW-1:0] reqAddr = '0;
  logic          rdy, hit, tagWe;
  logic [LW-1:0] tagAddr;
  logic [7:0]    tagWrData;
  logic [7:0]    tagRdData;

  always #2.5 clk = ~clk;  // 200 MHz

  tag_sweep_ctrl #(.NUM_LINES(N)) u_dut (
    .clk(clk), .rstN(rstN), .instantAck(instantAck), .ads(ads),
    .reqKind(reqKind), .reqAddr(reqAddr), .rdy(rdy), .hit(hit),
    .tagAddr(tagAddr), .tagWrData(tagWrData), .tagWe(tagWe),
    .tagRdData(tagRdData)
  );

  // Bench tag RAM: synchronous read, one-cycle latency
  logic [7:0] ram [N];
  always @(posedge clk) begin
    if (tagWe) ram[tagAddr] <= tagWrData;
    tagRdData <= ram[tagAddr];
  end

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int sweepPos = 0;
  int weCount  = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Sweep order monitor: clears (zero data) must walk 0..N-1 (R4)
  always @(posedge clk) begin
    if (rstN && tagWe) begin
      weCount++;
      if (tagWrData == 8'h00) begin
        chk("R4", "clear order", 32'(tagAddr), 32'(sweepPos));
        sweepPos++;
      end
    end
  end

  // Behavioural cycle model
  logic [7:0] mMem [N];
  bit         mSlotV, mBusy, expRdy, expHit, curHit;
  logic [1:0] mSlotK, curK;
  logic [RW-1:0] mSlotA, curA;
  int         mCnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSlotV = 0; mBusy = 0; expRdy = 0; expHit = 0; mCnt = 0;
    end else begin
      bit slotWas;
      slotWas = mSlotV;
      expRdy = 0; expHit = 0;
      if (mBusy) begin
        mCnt--;
        if (mCnt == 0) begin
          mBusy  = 0;
          expRdy = 1;
          if (curK[1]) begin
            for (int i = 0; i < N; i++) mMem[i] = 8'h00;
          end else if (curK[0]) begin
            mMem[curA[LW-1:0]] = {1'b1, curA[RW-1:LW]};
          end else begin
            expHit = curHit;
          end
        end
      end else if (mSlotV) begin
        mSlotV = 0;
        curK = mSlotK; curA = mSlotA;
        if (curK[1] && instantAck) begin
          expRdy = 1;
        end else begin
          mBusy = 1;
          mCnt  = curK[1] ? 2 * N : (curK[0] ? 1 : 2);
          curHit = mMem[curA[LW-1:0]][7] &&
                   (mMem[curA[LW-1:0]][6:0] == curA[RW-1:LW]);
        end
      end
      if (!slotWas && ads) begin
        mSlotV = 1; mSlotK = reqKind; mSlotA = reqAddr;
      end
    end
  end

  // Per-cycle compare against the model (R9, R2)
  always @(negedge clk) begin
    if (rstN) begin
      chk("R9", "rdy vs model", 32'(rdy), 32'(expRdy));
      chk("R2", "hit vs model", 32'(hit), 32'(expHit));
    end
  end

  function automatic logic [RW-1:0] mk(logic [6:0] tag, int idx);
    return {tag, LW'(idx)};
  endfunction

  task automatic pulse(logic [1:0] k, logic [RW-1:0] a);
    @(negedge clk);
    ads = 1'b1; reqKind = k; reqAddr = a;
    @(negedge clk);
    ads = 1'b0;
  endtask

  task automatic waitRdy(output int lat, output logic h);
    lat = 0;
    while (!rdy && lat < 4 * N + 20) begin
      @(negedge clk);
      lat++;
    end
    h = hit;
  endtask

  task automatic doReq(logic [1:0] k, logic [RW-1:0] a, output int lat, output logic h);
    pulse(k, a);
    waitRdy(lat, h);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD) begin
      fails++;
      $display("FAIL R5 watchdog: actual %0d cycles expected below %0d", cyc, WD);
      summary();
      $finish;
    end
  end

  initial begin
    int lat;
    logic h;
    int wBefore;
    bit allZero;
    // Preload: every third line valid, tag = 3*i+1
    for (int i = 0; i < N; i++) begin
      ram[i]  = {(i % 3 == 0), 7'(3 * i + 1)};
      mMem[i] = ram[i];
    end
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8", "rdy in reset", 32'(rdy), 0);
    chk("R8", "hit in reset", 32'(hit), 0);
    chk("R8", "tagWe in reset", 32'(tagWe), 0);
    rstN = 1'b1;

    // R8 / R2: preloaded valid entry survives reset and hits
    doReq(2'b00, mk(7'(28), 9), lat, h);
    chk("R8", "preload hit", 32'(h), 1);
    chk("R2", "lookup latency", lat, 3);
    // R2: tag mismatch
    doReq(2'b00, mk(7'(5), 9), lat, h);
    chk("R2", "tag mismatch", 32'(h), 0);
    // R2: tag match but valid clear
    doReq(2'b00, mk(7'(31), 10), lat, h);
    chk("R2", "invalid entry", 32'(h), 0);

    // R3 / R1: fill
    doReq(2'b01, mk(7'h2A, 5), lat, h);
    chk("R3", "fill latency", lat, 2);
    chk("R1", "fill entry", 32'(ram[5]), 32'h000000AA);
    doReq(2'b00, mk(7'h2A, 5), lat, h);
    chk("R3", "hit after fill", 32'(h), 1);

    // R6: instant acknowledge leaves tags alone
    instantAck = 1'b1;
    wBefore = weCount;
    doReq(2'b10, '0, lat, h);
    chk("R6", "instant latency", lat, 1);
    chk("R6", "no tag writes", weCount, wBefore);
    doReq(2'b00, mk(7'h2A, 5), lat, h);
    chk("R6", "hit survives", 32'(h), 1);
    instantAck = 1'b0;

    // R4 / R5: full sweep
    sweepPos = 0;
    doReq(2'b11, '0, lat, h);
    chk("R5", "sweep latency", lat, 2 * N + 1);
    chk("R4", "lines cleared", sweepPos, N);
    allZero = 1;
    for (int i = 0; i < N; i++) if (ram[i] != 8'h00) allZero = 0;
    chk("R4", "ram all zero", 32'(allZero), 1);
    doReq(2'b00, mk(7'h2A, 5), lat, h);
    chk("R4", "miss after sweep", 32'(h), 0);
    doReq(2'b00, mk(7'(28), 9), lat, h);
    chk("R4", "preload gone", 32'(h), 0);

    // R7: fill strobed mid-sweep is held until the sweep ends
    sweepPos = 0;
    pulse(2'b10, '0);
    repeat (3) @(negedge clk);
    pulse(2'b01, mk(7'h11, 3));
    waitRdy(lat, h);
    chk("R7", "sweep done first", sweepPos, N);
    chk("R7", "held fill not written", 32'(ram[3]), 0);
    @(negedge clk);
    waitRdy(lat, h);
    chk("R7", "held fill written", 32'(ram[3]), 32'h00000091);
    doReq(2'b00, mk(7'h12, 3), lat, h);
    chk("R2", "other tag same line", 32'(h), 0);
    doReq(2'b00, mk(7'h11, 3), lat, h);
    chk("R7", "held fill hits", 32'(h), 1);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule